// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a TFT panel: horizontal sync, vertical sync, a data-enable strobe, a launch-edge select level, a one-cycle frame-start pulse, and the current x/y raster position. It runs on the pixel clock and advances one position per cycle. Pixel fetch, clock generation and bus mastering are handled elsewhere. A pixel pipeline uses the position and data-enable outputs to decide when to present pixel data.

Software programs three 32-bit words through a simple write port: a horizontal timing word, a vertical timing word and a control word. Every line runs through four phases in a fixed order: active, front porch, sync, back porch. The same four phases make up a frame, counted in lines. Most fields hold the length minus one. The two vertical porches hold the plain line count, so either one may be zero. The block takes a working copy of the words only while it is stopped. Setting the enable bit starts the raster from the first pixel of line 0.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line is active for W = (htim[7:2]+1)*16 cycles, then has a front porch of htim[23:16]+1 cycles, a sync of htim[15:8]+1 cycles and a back porch of htim[31:24]+1 cycles, in that order. The horizontal sync strobe is asserted only during the sync phase.
- R2: Each frame is active for vtim[9:0]+1 lines, then has a front porch of vtim[23:16] lines (zero allowed), a sync of vtim[15:10]+1 lines and a back porch of vtim[31:24] lines (zero allowed). The line counter advances once per completed line, and the vertical sync strobe is asserted for every cycle of the sync lines.
- R3: The data-enable strobe is asserted only when the pixel position x < W, x <= ctrl[25:16] and the line lies in the active lines.
- R4: Setting ctrl[12] inverts horizontal sync, ctrl[11] inverts vertical sync and ctrl[14] inverts data-enable. The level of ctrl[13] drives pclk_fall_o (1 means data is launched on the falling pixel-clock edge).
- R5: frame_start_o is high for exactly one cycle, at x = 0 on line 0 of every frame.
- R6: pix_x_o and pix_y_o give the current position within the whole line and frame, porches included, counting from 0.
- R7: ctrl[0] is the enable bit. In the second cycle after the enable bit is written as 1, the raster is at x = 0, y = 0. While the block is stopped, the position is 0, frame_start_o is low and each strobe sits at its deasserted level after polarity.
- R8: Timing, polarity and edge fields written while the block runs have no effect until the block is stopped and started again.
- R9: Writes select the horizontal word at address 0, the vertical word at 1 and the control word at 2. After reset all words are zero, the block is stopped and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, after polarity |
| vsync_o | output | 1 | Vertical sync, after polarity |
| de_o | output | 1 | Data enable, after polarity |
| pclk_fall_o | output | 1 | Launch-edge select level |
| frame_start_o | output | 1 | One-cycle pulse at the first pixel of a frame |
| pix_x_o | output | H_W | Current pixel position in the line |
| pix_y_o | output | V_W | Current line in the frame |

## Verification
The bench checks every output against a cycle-exact model of the phase boundaries for three geometries. It looks for off-by-one errors in the minus-one fields: a design that added one to the vertical porches would stretch the frame by a line and shift vertical sync. A zero vertical front porch is tested, since a design that assumed at least one porch line would misplace sync or hang the line counter. Data-enable is cut short by a small clocks-per-line value, so a design that ignored that field would hold data-enable for too many pixels. Fields rewritten while the block runs must leave the scan and polarity unchanged until the block is restarted, and a design without the frozen copy would change timing in the middle of a frame.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    REG_HTIM = 2'd0,
    REG_VTIM = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [5:0] ppl;
    logic [7:0] hsw;
    logic [7:0] hfp;
    logic [7:0] hbp;
    logic [9:0] lpp;
    logic [5:0] vsw;
    logic [7:0] vfp;
    logic [7:0] vbp;
    logic [9:0] cpl;
    logic       inv_hs;
    logic       inv_vs;
    logic       inv_de;
    logic       pclk_fall;
  } timing_cfg_t;

  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_INV_VS = 11;
  localparam int unsigned CTRL_INV_HS = 12;
  localparam int unsigned CTRL_PCLKF  = 13;
  localparam int unsigned CTRL_INV_DE = 14;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output timing_cfg_t       cfg_o,
  output logic              run_o
);
  timing_cfg_t shadow_q, cfg_q;
  logic        en_q, run_q;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data_i[1:0], wr_data_i[10:1], wr_data_i[15], wr_data_i[31:26]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      en_q     <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_HTIM: begin
          shadow_q.ppl <= wr_data_i[7:2];
          shadow_q.hsw <= wr_data_i[15:8];
          shadow_q.hfp <= wr_data_i[23:16];
          shadow_q.hbp <= wr_data_i[31:24];
        end
        REG_VTIM: begin
          shadow_q.lpp <= wr_data_i[9:0];
          shadow_q.vsw <= wr_data_i[15:10];
          shadow_q.vfp <= wr_data_i[23:16];
          shadow_q.vbp <= wr_data_i[31:24];
        end
        REG_CTRL: begin
          en_q               <= wr_data_i[CTRL_EN];
          shadow_q.inv_vs    <= wr_data_i[CTRL_INV_VS];
          shadow_q.inv_hs    <= wr_data_i[CTRL_INV_HS];
          shadow_q.pclk_fall <= wr_data_i[CTRL_PCLKF];
          shadow_q.inv_de    <= wr_data_i[CTRL_INV_DE];
          shadow_q.cpl       <= wr_data_i[25:16];
        end
        default: ;
      endcase
    end
  end

  // working copy follows the shadow only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= en_q;
      if (!run_q) cfg_q <= shadow_q;
    end
  end

  assign cfg_o = cfg_q;
  assign run_o = run_q;
endmodule

// File: rtl/lcdt_phase_cnt.sv
module lcdt_phase_cnt
  import lcdt_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] len_act_i,
  input  logic [W-1:0] len_fp_i,
  input  logic [W-1:0] len_sync_i,
  input  logic [W-1:0] len_bp_i,
  output logic [W-1:0] cnt_o,
  output phase_e       phase_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] end_fp, end_sync, total;

  always_comb begin
    end_fp   = len_act_i + len_fp_i;
    end_sync = end_fp + len_sync_i;
    total    = end_sync + len_bp_i;
  end

  always_comb begin
    if (cnt_q < len_act_i)     phase_o = PH_ACT;
    else if (cnt_q < end_fp)   phase_o = PH_FP;
    else if (cnt_q < end_sync) phase_o = PH_SYNC;
    else                       phase_o = PH_BP;
  end

  assign last_o = (cnt_q == total - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int unsigned H_W = 12,
  parameter int unsigned V_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_fall_o,
  output logic              frame_start_o,
  output logic [H_W-1:0]    pix_x_o,
  output logic [V_W-1:0]    pix_y_o
);
  localparam int unsigned N_STROBE = 3;

  timing_cfg_t cfg;
  logic        running;

  lcdt_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg),
    .run_o    (running)
  );

  logic [6:0]     ppl_p1;
  logic [H_W-1:0] h_act, h_fp, h_sync, h_bp;
  logic [V_W-1:0] v_act, v_fp, v_sync, v_bp;

  always_comb begin
    ppl_p1 = {1'b0, cfg.ppl} + 7'd1;
    h_act  = H_W'({ppl_p1, 4'b0000});
    h_fp   = H_W'({1'b0, cfg.hfp} + 9'd1);
    h_sync = H_W'({1'b0, cfg.hsw} + 9'd1);
    h_bp   = H_W'({1'b0, cfg.hbp} + 9'd1);
    v_act  = V_W'({1'b0, cfg.lpp} + 11'd1);
    v_fp   = V_W'(cfg.vfp);
    v_sync = V_W'({1'b0, cfg.vsw} + 7'd1);
    v_bp   = V_W'(cfg.vbp);
  end

  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  phase_e         h_ph, v_ph;
  logic           h_last, v_last;

  lcdt_phase_cnt #(.W(H_W)) u_hcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .step_i    (1'b1),
    .len_act_i (h_act),
    .len_fp_i  (h_fp),
    .len_sync_i(h_sync),
    .len_bp_i  (h_bp),
    .cnt_o     (h_cnt),
    .phase_o   (h_ph),
    .last_o    (h_last)
  );

  lcdt_phase_cnt #(.W(V_W)) u_vcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .step_i    (h_last),
    .len_act_i (v_act),
    .len_fp_i  (v_fp),
    .len_sync_i(v_sync),
    .len_bp_i  (v_bp),
    .cnt_o     (v_cnt),
    .phase_o   (v_ph),
    .last_o    (v_last)
  );

  logic unused_vlast;
  assign unused_vlast = v_last;

  logic [N_STROBE-1:0] strobe_raw, strobe_inv, strobe_out;

  always_comb begin
    strobe_raw[0] = running && (h_ph == PH_SYNC);
    strobe_raw[1] = running && (v_ph == PH_SYNC);
    strobe_raw[2] = running && (h_ph == PH_ACT) && (v_ph == PH_ACT)
                    && (h_cnt <= H_W'(cfg.cpl));
    strobe_inv    = {cfg.inv_de, cfg.inv_vs, cfg.inv_hs};
  end

  for (genvar i = 0; i < N_STROBE; i++) begin : g_pol
    assign strobe_out[i] = strobe_raw[i] ^ strobe_inv[i];
  end

  assign hsync_o       = strobe_out[0];
  assign vsync_o       = strobe_out[1];
  assign de_o          = strobe_out[2];
  assign pclk_fall_o   = cfg.pclk_fall;
  assign frame_start_o = running && (h_cnt == '0) && (v_cnt == '0);
  assign pix_x_o       = running ? h_cnt : '0;
  assign pix_y_o       = running ? v_cnt : '0;
endmodule

module lcd_timing_gen_chk
  import lcdt_pkg::*;
#(
  parameter int unsigned H_W = 12,
  parameter int unsigned V_W = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           running,
  input timing_cfg_t    cfg,
  input logic [H_W-1:0] h_act,
  input logic [H_W-1:0] h_cnt,
  input logic           de_o,
  input logic           frame_start_o,
  input logic [H_W-1:0] pix_x_o,
  input logic [V_W-1:0] pix_y_o
);
  // R3
  de_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o ^ cfg.inv_de) |-> (pix_x_o < h_act));

  // R5
  fs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  // R5
  fs_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (pix_x_o == '0) && (pix_y_o == '0));

  // R6
  x_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running) && pix_x_o != '0) |-> (pix_x_o == $past(pix_x_o) + H_W'(1)));

  // R2
  y_at_line_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running) && pix_y_o != $past(pix_y_o)) |-> (pix_x_o == '0));

  // R7
  idle_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !$past(running)) |-> (h_cnt == '0));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running)) |-> $stable(cfg));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .running      (running),
  .cfg          (cfg),
  .h_act        (h_act),
  .h_cnt        (h_cnt),
  .de_o         (de_o),
  .frame_start_o(frame_start_o),
  .pix_x_o      (pix_x_o),
  .pix_y_o      (pix_y_o)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  localparam int H_W = 12;
  localparam int V_W = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic           hsync, vsync, de, pclk_fall, fstart;
  logic [H_W-1:0] px;
  logic [V_W-1:0] py;

  int n_chk = 0;
  int n_fail = 0;

  // model of the programmed geometry (raw field values)
  int m_ppl, m_hsw, m_hfp, m_hbp, m_lpp, m_vsw, m_vfp, m_vbp, m_cpl;
  int m_ihs, m_ivs, m_ide, m_pcf;

  always #10 clk = ~clk;

  lcd_timing_gen #(.H_W(H_W), .V_W(V_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .hsync_o      (hsync),
    .vsync_o      (vsync),
    .de_o         (de),
    .pclk_fall_o  (pclk_fall),
    .frame_start_o(fstart),
    .pix_x_o      (px),
    .pix_y_o      (py)
  );

  task automatic chk(string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, nm, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = 32'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int htim_w(int ppl, int hsw, int hfp, int hbp);
    return (hbp << 24) | (hfp << 16) | (hsw << 8) | (ppl << 2);
  endfunction

  function automatic int vtim_w(int lpp, int vsw, int vfp, int vbp);
    return (vbp << 24) | (vfp << 16) | (vsw << 10) | lpp;
  endfunction

  function automatic int ctrl_w(int cpl, int ihs, int ivs, int ide, int pcf, int en);
    return (cpl << 16) | (ide << 14) | (pcf << 13) | (ihs << 12) | (ivs << 11) | en;
  endfunction

  task automatic set_h(int ppl, int hsw, int hfp, int hbp);
    m_ppl = ppl; m_hsw = hsw; m_hfp = hfp; m_hbp = hbp;
  endtask

  task automatic set_v(int lpp, int vsw, int vfp, int vbp);
    m_lpp = lpp; m_vsw = vsw; m_vfp = vfp; m_vbp = vbp;
  endtask

  task automatic set_c(int cpl, int ihs, int ivs, int ide, int pcf);
    m_cpl = cpl; m_ihs = ihs; m_ivs = ivs; m_ide = ide; m_pcf = pcf;
  endtask

  function automatic int htot();
    return (m_ppl + 1) * 16 + m_hfp + 1 + m_hsw + 1 + m_hbp + 1;
  endfunction

  function automatic int vtot();
    return m_lpp + 1 + m_vfp + m_vsw + 1 + m_vbp;
  endfunction

  // check cycles k0 .. k0+n-1 after the start of the raster
  task automatic scan(int k0, int n);
    for (int k = k0; k < k0 + n; k++) begin
      int ht = htot();
      int vt = vtot();
      int w  = (m_ppl + 1) * 16;
      int l  = m_lpp + 1;
      int x  = k % ht;
      int y  = (k / ht) % vt;
      int hs_s = w + m_hfp + 1;
      int vs_s = l + m_vfp;
      int e_hs = ((x >= hs_s && x < hs_s + m_hsw + 1) ? 1 : 0) ^ m_ihs;
      int e_vs = ((y >= vs_s && y < vs_s + m_vsw + 1) ? 1 : 0) ^ m_ivs;
      int e_de = ((x < w && x <= m_cpl && y < l) ? 1 : 0) ^ m_ide;
      int e_fs = (x == 0 && y == 0) ? 1 : 0;
      chk("R1/R4", "hsync", int'(hsync), e_hs);
      chk("R2/R4", "vsync", int'(vsync), e_vs);
      chk("R3/R4", "de", int'(de), e_de);
      chk("R5", "frame_start", int'(fstart), e_fs);
      chk("R6", "pix_x", int'(px), x);
      chk("R6", "pix_y", int'(py), y);
      chk("R4", "pclk_fall", int'(pclk_fall), m_pcf);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R9", "hsync", int'(hsync), 0);
    chk("R9", "vsync", int'(vsync), 0);
    chk("R9", "de", int'(de), 0);
    chk("R9", "frame_start", int'(fstart), 0);
    chk("R9", "pclk_fall", int'(pclk_fall), 0);
    chk("R9", "pix_x", int'(px), 0);
    chk("R9", "pix_y", int'(py), 0);
  endtask

  // geometry A: 16 px, fp 2, sync 3, bp 1; 3 lines, fp 1, sync 2, bp 0
  task automatic t_basic();
    set_h(0, 2, 1, 0);
    set_v(2, 1, 1, 0);
    set_c(15, 0, 0, 0, 0);
    wr(0, htim_w(0, 2, 1, 0));
    wr(1, vtim_w(2, 1, 1, 0));
    wr(3, 32'hffff_ffff);  // unmapped address, R9
    wr(2, ctrl_w(15, 0, 0, 0, 0, 1));
    @(negedge clk);
    chk("R7", "start_x", int'(px), 0);
    scan(0, 2 * htot() * vtot());
  endtask

  // R8: writes during a run leave the raster untouched
  task automatic t_running_write(int k);
    wr(0, htim_w(1, 1, 0, 2));
    wr(2, ctrl_w(20, 1, 1, 1, 1, 1));
    scan(k + 2, 140);
  endtask

  task automatic t_disable();
    wr(2, ctrl_w(20, 1, 1, 1, 1, 0));
    repeat (3) @(negedge clk);
    chk("R7", "idle hsync", int'(hsync), 1);
    chk("R7", "idle vsync", int'(vsync), 1);
    chk("R7", "idle de", int'(de), 1);
    chk("R7", "idle frame_start", int'(fstart), 0);
    chk("R7", "idle pix_x", int'(px), 0);
    chk("R7", "idle pix_y", int'(py), 0);
    chk("R4", "idle pclk_fall", int'(pclk_fall), 1);
  endtask

  // pending writes take effect on restart; all strobes inverted, short DE
  task automatic t_reenable();
    set_h(1, 1, 0, 2);
    set_c(20, 1, 1, 1, 1);
    wr(2, ctrl_w(20, 1, 1, 1, 1, 1));
    @(negedge clk);
    chk("R8", "restart frame_start", int'(fstart), 1);
    scan(0, 2 * htot() * vtot());
  endtask

  // R2: zero vertical front porch, two-line back porch
  task automatic t_zero_porch();
    wr(2, ctrl_w(15, 0, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    set_v(1, 0, 0, 2);
    set_c(15, 0, 0, 0, 0);
    wr(1, vtim_w(1, 0, 0, 2));
    wr(2, ctrl_w(15, 0, 0, 0, 0, 1));
    @(negedge clk);
    scan(0, 2 * htot() * vtot());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_running_write(2 * 132);
    t_disable();
    t_reenable();
    t_zero_porch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule